// File: doc/BRIEF.md
# Compare-Clear Timer with Control/Status Register

This block is an up-counting timer with a programmable period. A prescaler divides the input clock by a power of two, and each divided tick advances the counter. When the counter holds the programmed compare value, the next tick returns it to zero and raises a sticky interrupt flag. The interrupt line is driven while the flag is set and interrupts are enabled.

Software controls the timer through a byte-wide register bus. Address 0 is the control/status byte. Address 1 holds the staged upper byte of the compare value. Address 2 takes the lower byte and commits the whole 16-bit compare value. Reads are combinational.

Two external strobes can also restart the counter. A mode bit picks which one is active: the write-timing strobe or the position-detection strobe. A read-modify-write indicator makes the flag read back as 1, so that a software read-modify-write cannot clear the flag by accident.

Top module: `cmpclr_timer`

## Requirements
- R1: After reset, every control/status bit is 0, the committed compare value reads back as 0, the count is 0 and `irq` is low.
- R2: The count advances only while the timer-enable bit (control bit 3) is 1. The divide select (control bits 2:0, value s) sets the step rate. After enabling, the counter steps on every 2^s-th clock edge, so after M edges it has taken floor(M/2^s) steps.
- R3: On a tick where the count equals the committed compare value, the count becomes 0 and the flag (control bit 5) becomes 1. The counter therefore cycles with period compare+1 ticks.
- R4: Writing the control byte with bit 5 = 0 clears the flag. Writing bit 5 = 1 leaves the flag unchanged.
- R5: A read of address 0 returns the flag bit as 1 while `rmw` is high. With `rmw` low, the bit reads as the actual flag.
- R6: `irq` is high exactly when the flag is 1 and the interrupt-enable bit (control bit 4) is 1.
- R7: Writing control bit 7 = 1 forces the count to 0 at that edge, whether or not the timer is running. Bit 7 always reads 0, and a write of bit 7 = 1 does not set the flag.
- R8: With mode (control bit 6) = 0, a high `wt_strobe` clears the count at the next edge and `pos_strobe` is ignored. With mode = 1, the roles of the two strobes are swapped.
- R9: If a compare match and a control write with bit 5 = 0 fall in the same cycle, the flag ends up 1.
- R10: A write to address 1 only stages the upper byte. Reads of addresses 1 and 2 return the committed value. The matching logic keeps using the old 16-bit value until address 2 is written, and that write commits both bytes together.
- R11: While the timer is disabled and no clear occurs, the count holds its value.
- R12: A strobe clear or a timer-clear write wins over a step or match in the same cycle, and it does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address (0 control/status, 1 compare upper, 2 compare lower) |
| wr_en | input | 1 | Write enable for the addressed register |
| wr_data | input | 8 | Write data |
| rmw | input | 1 | Read-modify-write access indicator |
| wt_strobe | input | 1 | Write-timing strobe, clears the count when mode = 0 |
| pos_strobe | input | 1 | Position-detection strobe, clears the count when mode = 1 |
| rd_data | output | 8 | Combinational read data for the addressed register |
| count | output | 16 | Current counter value |
| irq | output | 1 | Compare-clear interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit register byte, a 16-bit counter and a 3-bit divide select.

It sweeps the divide select over 0 to 3 and the compare value over 0, 3 and 6. For each combination it checks the count after every edge against floor(M/2^s) mod (compare+1). That brings the wrap, the flag-set point and the cmp = 0 corner within a few tens of cycles.

Directed sequences then place a strobe or a flag write on the exact cycle of a match. This exercises the priority rules and the staged compare commit.

// File: rtl/cmpclr_pkg.sv
// Shared constants for the compare-clear timer: register byte width,
// address map and control/status bit positions.
package cmpclr_pkg;
    localparam int REG_W  = 8;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CSR    = 2'd0,
        A_CMP_HI = 2'd1,
        A_CMP_LO = 2'd2,
        A_SPARE  = 2'd3
    } reg_addr_e;

    localparam int B_TCLR = 7;
    localparam int B_MODE = 6;
    localparam int B_FLAG = 5;
    localparam int B_IE   = 4;
    localparam int B_TEN  = 3;
endpackage

// File: rtl/cmpclr_regs.sv
// Register file of the compare-clear timer.
// Holds the control/status byte, the staged upper compare byte and the
// committed compare value. It also drives the read mux.
// Assumes a single-cycle write strobe. Reads are combinational.
module cmpclr_regs
    import cmpclr_pkg::*;
#(
    parameter int BW   = REG_W,
    parameter int SW   = SEL_W,
    parameter int AW   = ADDR_W,
    parameter int CW   = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_data,
    input  logic          rmw,
    input  logic          match,
    output logic [BW-1:0] rd_data,
    output logic          mode,
    output logic          ie,
    output logic          ten,
    output logic [SW-1:0] sel,
    output logic [CW-1:0] cmp,
    output logic          flag,
    output logic          tclr_wr
);
    logic          wr_csr;
    logic [BW-1:0] stage_hi;

    assign wr_csr  = wr_en && (addr == AW'(A_CSR));
    assign tclr_wr = wr_csr && wr_data[B_TCLR];

    // Control fields: loaded on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= 1'b0;
            ie   <= 1'b0;
            ten  <= 1'b0;
            sel  <= '0;
        end else if (wr_csr) begin
            mode <= wr_data[B_MODE];
            ie   <= wr_data[B_IE];
            ten  <= wr_data[B_TEN];
            sel  <= wr_data[SW-1:0];
        end
    end

    // Sticky flag: a match sets it and wins over a write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (match)
            flag <= 1'b1;
        else if (wr_csr && !wr_data[B_FLAG])
            flag <= 1'b0;
    end

    // Compare value: the upper byte is staged and the lower-byte write commits both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_hi <= '0;
            cmp      <= '0;
        end else if (wr_en && addr == AW'(A_CMP_HI)) begin
            stage_hi <= wr_data;
        end else if (wr_en && addr == AW'(A_CMP_LO)) begin
            cmp <= {stage_hi, wr_data};
        end
    end

    // Read mux: the flag reads as 1 during read-modify-write, and timer clear reads as 0.
    always_comb begin
        rd_data = '0;
        case (addr)
            AW'(A_CSR): begin
                rd_data[B_MODE]  = mode;
                rd_data[B_FLAG]  = flag | rmw;
                rd_data[B_IE]    = ie;
                rd_data[B_TEN]   = ten;
                rd_data[SW-1:0]  = sel;
            end
            AW'(A_CMP_HI): rd_data = cmp[CW-1:BW];
            AW'(A_CMP_LO): rd_data = cmp[BW-1:0];
            default:       rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cmpclr_prescaler.sv
// Power-of-two clock prescaler.
// Emits a one-cycle tick every 2^sel cycles while run is high.
// Assumes the phase restarts from zero whenever run is low.
module cmpclr_prescaler #(
    parameter int SW = 3,
    parameter int PW = (1 << SW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [SW-1:0] sel,
    output logic          tick
);
    logic [PW-1:0] phase;
    logic [PW:0]   span;
    logic [PW-1:0] mask;

    assign span = (PW + 1)'(1) << sel;
    assign mask = PW'(span - (PW + 1)'(1));
    assign tick = run && ((phase & mask) == mask);

    // Phase counter: free-running while enabled, parked at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            phase <= '0;
        else
            phase <= phase + PW'(1);
    end
endmodule

// File: rtl/cmpclr_counter.sv
// Timer counter with compare-clear.
// A clear event (timer-clear write or the mode-selected strobe) wins over
// counting. On a tick at the compare value the count wraps to zero and
// match pulses. Assumes cmp is stable in the cycle it is used.
module cmpclr_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tclr_wr,
    input  logic          mode,
    input  logic          wt_strobe,
    input  logic          pos_strobe,
    input  logic [CW-1:0] cmp,
    output logic [CW-1:0] count,
    output logic          clr_evt,
    output logic          match
);
    logic at_cmp;

    assign clr_evt = tclr_wr | (mode ? pos_strobe : wt_strobe);
    assign at_cmp  = (count == cmp);
    assign match   = tick && at_cmp && !clr_evt;

    // Count register: a clear first, then a wrap or a step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr_evt)
            count <= '0;
        else if (tick)
            count <= at_cmp ? '0 : count + CW'(1);
    end
endmodule

// File: rtl/cmpclr_timer.sv
// Top level of the compare-clear timer.
// Ties together the register file, the prescaler and the counter.
// Assumes a synchronous byte-wide bus and strobes synchronous to clk.
module cmpclr_timer
    import cmpclr_pkg::*;
#(
    parameter int BW = REG_W,
    parameter int SW = SEL_W,
    parameter int AW = ADDR_W,
    parameter int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_data,
    input  logic          rmw,
    input  logic          wt_strobe,
    input  logic          pos_strobe,
    output logic [BW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          irq
);
    logic          mode, ie, ten, flag, tclr_wr, match, tick, clr_evt;
    logic [SW-1:0] sel;
    logic [CW-1:0] cmp;

    cmpclr_regs #(.BW(BW), .SW(SW), .AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rmw(rmw), .match(match), .rd_data(rd_data),
        .mode(mode), .ie(ie), .ten(ten), .sel(sel), .cmp(cmp),
        .flag(flag), .tclr_wr(tclr_wr)
    );

    cmpclr_prescaler #(.SW(SW)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(ten), .sel(sel), .tick(tick)
    );

    cmpclr_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tclr_wr(tclr_wr),
        .mode(mode), .wt_strobe(wt_strobe), .pos_strobe(pos_strobe),
        .cmp(cmp), .count(count), .clr_evt(clr_evt), .match(match)
    );

    // Interrupt gate.
    assign irq = flag & ie;
endmodule

// File: rtl/cmpclr_timer_chk.sv
// Assertion checker for the compare-clear timer, bound into the top.
// Observes ports and inter-module signals only.
module cmpclr_timer_chk #(
    parameter int BW = 8,
    parameter int AW = 2,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic [BW-1:0] wr_data,
    input logic          rmw,
    input logic          wt_strobe,
    input logic          pos_strobe,
    input logic [BW-1:0] rd_data,
    input logic [CW-1:0] count,
    input logic          tick,
    input logic          mode,
    input logic          ten,
    input logic [CW-1:0] cmp,
    input logic          flag,
    input logic          clr_evt
);
    assert_tclr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> !rd_data[7]);

    assert_rmw_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0 && rmw) |-> rd_data[5]);

    assert_tclr_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && wr_data[7]) |=> (count == '0));

    assert_strobe_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((!mode && wt_strobe) || (mode && pos_strobe)) |=> (count == '0));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ten && !clr_evt) |=> $stable(count));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count != cmp && !clr_evt) |=> (count == $past(count) + CW'(1)));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == cmp && !clr_evt) |=> (count == '0 && flag));

    assert_clear_no_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !flag) |=> !flag);
endmodule

bind cmpclr_timer cmpclr_timer_chk #(.BW(BW), .AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rmw(rmw), .wt_strobe(wt_strobe), .pos_strobe(pos_strobe),
    .rd_data(rd_data), .count(count), .tick(tick), .mode(mode), .ten(ten),
    .cmp(cmp), .flag(flag), .clr_evt(clr_evt)
);

// File: tb/cmpclr_timer_test.sv
module cmpclr_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rmw = 1'b0;
    logic        wt_strobe = 1'b0;
    logic        pos_strobe = 1'b0;
    logic [7:0]  rd_data;
    logic [15:0] count;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    cmpclr_timer uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rmw(rmw), .wt_strobe(wt_strobe),
        .pos_strobe(pos_strobe), .rd_data(rd_data), .count(count), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, input logic r, output logic [7:0] d);
        addr = a; rmw = r;
        #1;
        d = rd_data;
        rmw = 1'b0;
    endtask

    task automatic set_cmp(input int v);
        reg_wr(2'd1, 8'((v >> 8) & 8'hff));
        reg_wr(2'd2, 8'(v & 8'hff));
    endtask

    task automatic pulse(input bit pos);
        if (pos) pos_strobe = 1'b1; else wt_strobe = 1'b1;
        @(negedge clk);
        pos_strobe = 1'b0; wt_strobe = 1'b0;
    endtask

    // Leaves the timer stopped with count == v (v >= 1), selected mode and flag kept.
    task automatic load_count(input int v, input bit m);
        reg_wr(2'd0, 8'h80 | (8'(m) << 6));
        reg_wr(2'd0, 8'h28 | (8'(m) << 6));
        repeat (v - 1) @(negedge clk);
        reg_wr(2'd0, 8'h20 | (8'(m) << 6));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int cmps[3] = '{0, 3, 6};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(2'd0, 1'b0, d); check("R1 csr", d, 8'h00);
        reg_rd(2'd1, 1'b0, d); check("R1 cmp_hi", d, 0);
        reg_rd(2'd2, 1'b0, d); check("R1 cmp_lo", d, 0);
        check("R1 count", count, 0);
        check("R1 irq", irq, 0);

        // R2 / R3 sweep of divide select and compare value
        foreach (cmps[ci]) begin
            for (int s = 0; s < 4; s++) begin
                set_cmp(cmps[ci]);
                reg_wr(2'd0, 8'h80);
                reg_wr(2'd0, 8'h28 | 8'(s));
                for (int k = 1; k <= 40; k++) begin
                    @(negedge clk);
                    check("R2 R3 count", count, (k >> s) % (cmps[ci] + 1));
                end
                reg_rd(2'd0, 1'b0, d);
                check("R3 flag", d[5], ((40 >> s) > cmps[ci]) ? 1 : 0);
                check("R6 irq ie=0", irq, 0);
            end
        end
        reg_wr(2'd0, 8'h80);

        // R4 / R6 flag write semantics and irq gate
        set_cmp(0);
        reg_wr(2'd0, 8'h38);
        reg_wr(2'd0, 8'h30);
        reg_rd(2'd0, 1'b0, d); check("R4 flag set", d[5], 1);
        check("R6 irq on", irq, 1);
        reg_wr(2'd0, 8'h30);
        reg_rd(2'd0, 1'b0, d); check("R4 write1 keeps", d[5], 1);
        reg_wr(2'd0, 8'h10);
        reg_rd(2'd0, 1'b0, d); check("R4 write0 clears", d[5], 0);
        check("R6 irq off flag0", irq, 0);
        reg_wr(2'd0, 8'h28);
        reg_wr(2'd0, 8'h20);
        reg_rd(2'd0, 1'b0, d); check("R6 flag w/o ie", d[5], 1);
        check("R6 irq off ie0", irq, 0);
        reg_wr(2'd0, 8'h00);

        // R5 read-modify-write readback
        reg_rd(2'd0, 1'b0, d); check("R5 normal read", d, 8'h00);
        reg_rd(2'd0, 1'b1, d); check("R5 rmw read", d, 8'h20);

        // R7 timer clear
        set_cmp(16'h1000);
        load_count(5, 1'b0);
        check("R7 preload", count, 5);
        reg_wr(2'd0, 8'h80);
        check("R7 clear stopped", count, 0);
        reg_rd(2'd0, 1'b0, d); check("R7 reads zero no flag", d, 8'h00);
        reg_wr(2'd0, 8'h28);
        repeat (4) @(negedge clk);
        reg_wr(2'd0, 8'hA8);
        check("R7 clear running", count, 0);
        @(negedge clk);
        check("R7 resumes", count, 1);

        // R11 hold while disabled
        load_count(5, 1'b0);
        repeat (4) @(negedge clk);
        check("R11 hold", count, 5);

        // R8 strobe selection by mode
        pulse(1'b1); check("R8 mode0 pos ignored", count, 5);
        pulse(1'b0); check("R8 mode0 wt clears", count, 0);
        load_count(7, 1'b1);
        pulse(1'b0); check("R8 mode1 wt ignored", count, 7);
        pulse(1'b1); check("R8 mode1 pos clears", count, 0);

        // R12 strobe beats a match
        set_cmp(3);
        reg_wr(2'd0, 8'h80);
        reg_wr(2'd0, 8'h28);
        repeat (3) @(negedge clk);
        check("R12 at cmp", count, 3);
        pulse(1'b0);
        check("R12 cleared", count, 0);
        reg_rd(2'd0, 1'b0, d); check("R12 no flag", d[5], 0);
        @(negedge clk);
        check("R12 counts on", count, 1);

        // R9 match beats write-0
        reg_wr(2'd0, 8'h80);
        reg_wr(2'd0, 8'h28);
        repeat (3) @(negedge clk);
        reg_wr(2'd0, 8'h08);
        reg_rd(2'd0, 1'b0, d); check("R9 match wins", d[5], 1);
        check("R9 wrapped", count, 0);
        reg_wr(2'd0, 8'h08);
        reg_rd(2'd0, 1'b0, d); check("R9 later clear", d[5], 0);

        // R10 staged compare upper byte
        reg_wr(2'd0, 8'h80);
        reg_wr(2'd1, 8'h01);
        reg_rd(2'd1, 1'b0, d); check("R10 hi not committed", d, 8'h00);
        reg_rd(2'd2, 1'b0, d); check("R10 lo unchanged", d, 8'h03);
        reg_wr(2'd0, 8'h28);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            check("R10 old compare used", count, k % 4);
        end
        reg_wr(2'd2, 8'h00);
        reg_rd(2'd1, 1'b0, d); check("R10 hi committed", d, 8'h01);
        reg_rd(2'd2, 1'b0, d); check("R10 lo committed", d, 8'h00);
        reg_wr(2'd0, 8'h80);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule